// File: doc/BRIEF.md
# Limited-Pointer Coherence Directory Entry

This block is the home-node controller for one cache block's directory entry in a 64-processor system that keeps caches coherent by invalidation. It does not keep a full bit vector of sharers. The entry holds one processor pointer and a holder mode: uncached, one shared holder, one exclusive holder, or global. Global mode means more than one processor may share the block. In that mode the pointer is ignored and every processor is treated as a possible sharer.

Shared-read and exclusive-write requests arrive on a valid/ready stream, and each carries the requester ID. The controller takes one request at a time and decides the invalidations that request needs. If it needs any, the controller issues one invalidate message on a valid/ready stream. That message is either directed at a single processor or a broadcast. The controller then counts the invalidate responses as they come back on a third stream. After the last response it sends a grant on a fourth valid/ready stream and updates the entry.

Every stream follows the same rule. A transfer happens on a clock edge where valid and ready are both high. A producer holds valid and its payload steady until that edge. The request input is not ready from the moment a request is taken until the grant for it has been accepted.

Top module: `ptr_dir_home`

## Requirements
- R1: After reset the entry is uncached, `req_ready` is 1, and `inv_valid`, `gnt_valid` and `inv_rsp_ready` are 0.
- R2: A read when the entry is uncached sends no invalidate. It is granted as shared (`gnt_excl`=0), and the requester becomes the sole shared holder.
- R3: A read by the processor that is already the sole shared holder sends no invalidate and leaves the entry unchanged.
- R4: A read by a different processor while one processor holds the block shared sends no invalidate and puts the entry in global mode. In global mode, reads send no invalidate.
- R5: A write in global mode sends one invalidate with `inv_bcast`=1 and `inv_dest` equal to the requester, meaning "all processors except this one". The grant follows only after NPROC-1 (63) responses.
- R6: A write while a single other processor holds the block, shared or exclusive, sends one directed invalidate (`inv_bcast`=0, `inv_dest` = that holder). The grant follows after one response.
- R7: `gnt_valid` stays 0 while any expected invalidate response is still outstanding.
- R8: An exclusive grant (`gnt_excl`=1) leaves the writer as the sole exclusive holder and clears global mode.
- R9: A read by another processor while one processor holds the block exclusive sends a directed invalidate to the holder. It is granted shared, and the reader becomes the sole shared holder.
- R10: A read or a write by the sole holder itself sends no invalidate. A write makes that processor the exclusive holder. The grant carries `gnt_excl`=1 exactly when the resulting mode is exclusive.
- R11: `req_ready` is 0 from the cycle after a request is accepted until the cycle after its grant is accepted.
- R12: While `inv_valid` or `gnt_valid` is 1 and the matching ready is 0, the valid and its payload stay unchanged on the next cycle.
- R13: `inv_rsp_ready` is 1 only while responses are outstanding. A response is never accepted when none is expected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_id | input | ID_W (6) | Requesting processor |
| req_wr | input | 1 | 1 = exclusive write, 0 = shared read |
| inv_valid | output | 1 | Invalidate message present |
| inv_ready | input | 1 | Network accepts the invalidate |
| inv_bcast | output | 1 | 1 = broadcast to all processors except `inv_dest` |
| inv_dest | output | ID_W (6) | Target processor, or the processor excluded from a broadcast |
| inv_rsp_valid | input | 1 | One invalidate response arrives |
| inv_rsp_ready | output | 1 | Controller is waiting for responses |
| gnt_valid | output | 1 | Grant present |
| gnt_ready | input | 1 | Network accepts the grant |
| gnt_id | output | ID_W (6) | Processor being granted |
| gnt_excl | output | 1 | 1 = exclusive grant, 0 = shared grant |

## Verification
The assertions check stream and counting rules on every cycle:
- the grant never appears while responses are outstanding;
- responses are never taken with none pending;
- stalled invalidate and grant payloads hold steady;
- the request input closes after acceptance;
- a broadcast only comes from an entry in global mode.

The entry transitions can only be seen across transaction sequences, because the pointer is not visible at the ports. These are a sole sharer re-reading, a second reader tipping the entry into global mode, an exclusive owner being read, and a writer replacing the record. The bench scenarios reveal them through the invalidate destinations and response counts of later requests.

// File: rtl/ptr_dir_pkg.sv
package ptr_dir_pkg;
  typedef enum logic [1:0] {
    HOLD_NONE   = 2'd0,
    HOLD_SHARED = 2'd1,
    HOLD_EXCL   = 2'd2,
    HOLD_GLOBAL = 2'd3
  } hold_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_INV   = 2'd1,
    PH_WAIT  = 2'd2,
    PH_GRANT = 2'd3
  } phase_e;
endpackage

// File: rtl/ptr_dir_decide.sv
module ptr_dir_decide
  import ptr_dir_pkg::*;
#(
  parameter int NPROC = 64,
  parameter int ID_W  = $clog2(NPROC),
  parameter int CNT_W = $clog2(NPROC + 1)
) (
  input  hold_e            hold,
  input  logic [ID_W-1:0]  holder_id,
  input  logic [ID_W-1:0]  req_id,
  input  logic             req_wr,
  output logic             need_inv,
  output logic             bcast,
  output logic [ID_W-1:0]  dest,
  output logic [CNT_W-1:0] rsp_cnt,
  output hold_e            next_hold,
  output logic [ID_W-1:0]  next_id
);
  localparam logic [CNT_W-1:0] ALL_OTHERS = CNT_W'(NPROC - 1);
  localparam logic [CNT_W-1:0] JUST_ONE   = CNT_W'(1);

  logic same;
  assign same = (holder_id == req_id);

  always_comb begin
    need_inv  = 1'b0;
    bcast     = 1'b0;
    dest      = holder_id;
    rsp_cnt   = '0;
    next_hold = hold;
    next_id   = holder_id;
    if (req_wr) begin
      next_hold = HOLD_EXCL;
      next_id   = req_id;
      case (hold)
        HOLD_SHARED, HOLD_EXCL: begin
          if (!same) begin
            need_inv = 1'b1;
            rsp_cnt  = JUST_ONE;
          end
        end
        HOLD_GLOBAL: begin
          need_inv = 1'b1;
          bcast    = 1'b1;
          dest     = req_id;
          rsp_cnt  = ALL_OTHERS;
        end
        default: ;
      endcase
    end else begin
      case (hold)
        HOLD_NONE: begin
          next_hold = HOLD_SHARED;
          next_id   = req_id;
        end
        HOLD_SHARED: begin
          if (!same) next_hold = HOLD_GLOBAL;
        end
        HOLD_EXCL: begin
          if (!same) begin
            need_inv  = 1'b1;
            rsp_cnt   = JUST_ONE;
            next_hold = HOLD_SHARED;
            next_id   = req_id;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ptr_dir_ackcnt.sv
module ptr_dir_ackcnt #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CNT_W'(1));

  // R13
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> cnt != '0);
endmodule

// File: rtl/ptr_dir_home.sv
module ptr_dir_home
  import ptr_dir_pkg::*;
#(
  parameter int NPROC = 64,
  parameter int ID_W  = $clog2(NPROC),
  parameter int CNT_W = $clog2(NPROC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [ID_W-1:0] req_id,
  input  logic            req_wr,
  output logic            inv_valid,
  input  logic            inv_ready,
  output logic            inv_bcast,
  output logic [ID_W-1:0] inv_dest,
  input  logic            inv_rsp_valid,
  output logic            inv_rsp_ready,
  output logic            gnt_valid,
  input  logic            gnt_ready,
  output logic [ID_W-1:0] gnt_id,
  output logic            gnt_excl
);
  phase_e           phase;
  hold_e            hold, pend_hold;
  logic [ID_W-1:0]  holder_id, pend_id;

  logic             d_need, d_bcast;
  logic [ID_W-1:0]  d_dest, d_next_id;
  logic [CNT_W-1:0] d_cnt, pend_cnt;
  hold_e            d_next_hold;
  logic             cnt_last, rsp_take, req_take;

  ptr_dir_decide #(.NPROC(NPROC), .ID_W(ID_W), .CNT_W(CNT_W)) u_decide (
    .hold(hold), .holder_id(holder_id), .req_id(req_id), .req_wr(req_wr),
    .need_inv(d_need), .bcast(d_bcast), .dest(d_dest), .rsp_cnt(d_cnt),
    .next_hold(d_next_hold), .next_id(d_next_id)
  );

  assign req_ready     = (phase == PH_IDLE);
  assign inv_valid     = (phase == PH_INV);
  assign inv_rsp_ready = (phase == PH_WAIT);
  assign gnt_valid     = (phase == PH_GRANT);
  assign req_take      = req_valid && req_ready;
  assign rsp_take      = inv_rsp_valid && inv_rsp_ready;

  ptr_dir_ackcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(req_take), .load_val(d_cnt),
    .dec(rsp_take), .cnt(pend_cnt), .last(cnt_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      hold      <= HOLD_NONE;
      holder_id <= '0;
      pend_hold <= HOLD_NONE;
      pend_id   <= '0;
      inv_bcast <= 1'b0;
      inv_dest  <= '0;
      gnt_id    <= '0;
      gnt_excl  <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (req_take) begin
          pend_hold <= d_next_hold;
          pend_id   <= d_next_id;
          inv_bcast <= d_bcast;
          inv_dest  <= d_dest;
          gnt_id    <= req_id;
          gnt_excl  <= (d_next_hold == HOLD_EXCL);
          phase     <= d_need ? PH_INV : PH_GRANT;
        end
        PH_INV:  if (inv_ready) phase <= PH_WAIT;
        PH_WAIT: if (rsp_take && cnt_last) phase <= PH_GRANT;
        PH_GRANT: if (gnt_ready) begin
          hold      <= pend_hold;
          holder_id <= pend_id;
          phase     <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R7
  grant_after_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> pend_cnt == '0);

  // R12
  inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && !inv_ready |=> inv_valid && $stable(inv_bcast) && $stable(inv_dest));

  // R12
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && !gnt_ready |=> gnt_valid && $stable(gnt_id) && $stable(gnt_excl));

  // R11
  req_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R5
  bcast_from_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && inv_bcast |-> hold == HOLD_GLOBAL);
endmodule

// File: tb/ptr_dir_home_test.sv
module ptr_dir_home_test;
  localparam int NPROC = 64;
  localparam int ID_W  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_wr = 1'b0;
  logic [ID_W-1:0] req_id = '0;
  logic inv_ready = 1'b0, inv_rsp_valid = 1'b0, gnt_ready = 1'b0;
  logic req_ready, inv_valid, inv_bcast, inv_rsp_ready, gnt_valid, gnt_excl;
  logic [ID_W-1:0] inv_dest, gnt_id;

  int checks = 0;
  int fails  = 0;
  int m_mode = 0;   // 0 none, 1 shared, 2 exclusive, 3 global
  int m_id   = 0;

  always #10 clk = ~clk;

  ptr_dir_home uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_wr(req_wr), .inv_valid(inv_valid), .inv_ready(inv_ready),
    .inv_bcast(inv_bcast), .inv_dest(inv_dest), .inv_rsp_valid(inv_rsp_valid),
    .inv_rsp_ready(inv_rsp_ready), .gnt_valid(gnt_valid), .gnt_ready(gnt_ready),
    .gnt_id(gnt_id), .gnt_excl(gnt_excl)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic predict(input int id, input bit wr, output bit e_inv, output bit e_bc,
                         output int e_dest, output int e_cnt, output int n_mode, output int n_id);
    e_inv = 0; e_bc = 0; e_dest = m_id; e_cnt = 0; n_mode = m_mode; n_id = m_id;
    if (wr) begin
      n_mode = 2; n_id = id;
      if ((m_mode == 1 || m_mode == 2) && m_id != id) begin e_inv = 1; e_cnt = 1; end
      if (m_mode == 3) begin e_inv = 1; e_bc = 1; e_dest = id; e_cnt = NPROC - 1; end
    end else begin
      if (m_mode == 0) begin n_mode = 1; n_id = id; end
      else if (m_mode == 1 && m_id != id) n_mode = 3;
      else if (m_mode == 2 && m_id != id) begin
        e_inv = 1; e_cnt = 1; n_mode = 1; n_id = id;
      end
    end
  endtask

  task automatic txn(input int id, input bit wr, input string tag);
    bit e_inv, e_bc;
    int e_dest, e_cnt, n_mode, n_id;
    predict(id, wr, e_inv, e_bc, e_dest, e_cnt, n_mode, n_id);
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", req_ready, 1);
    req_valid = 1'b1; req_id = ID_W'(id); req_wr = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11", req_ready, 0);
    chk(inv_valid == e_inv, tag, inv_valid, e_inv);
    if (e_inv && inv_valid) begin
      chk(inv_bcast == e_bc, tag, inv_bcast, e_bc);
      chk(inv_dest == ID_W'(e_dest), tag, inv_dest, e_dest);
      chk(inv_rsp_ready == 1'b0, "R13", inv_rsp_ready, 0);
      for (int d = 0; d < int'($urandom_range(0, 2)); d++) begin
        @(negedge clk);
        chk(inv_valid && inv_bcast == e_bc && inv_dest == ID_W'(e_dest), "R12", inv_valid, 1);
      end
      inv_ready = 1'b1;
      @(negedge clk);
      inv_ready = 1'b0;
      chk(inv_rsp_ready == 1'b1, "R13", inv_rsp_ready, 1);
      for (int k = 0; k < e_cnt; k++) begin
        if ($urandom_range(0, 3) == 0) begin
          @(negedge clk);
          chk(gnt_valid == 1'b0, "R7", gnt_valid, 0);
        end
        inv_rsp_valid = 1'b1;
        @(negedge clk);
        inv_rsp_valid = 1'b0;
        if (k < e_cnt - 1) chk(gnt_valid == 1'b0, "R7", gnt_valid, 0);
      end
      chk(inv_rsp_ready == 1'b0, "R13", inv_rsp_ready, 0);
    end
    chk(gnt_valid == 1'b1, "R7", gnt_valid, 1);
    chk(gnt_id == ID_W'(id), tag, gnt_id, id);
    chk(gnt_excl == (n_mode == 2), "R10", gnt_excl, int'(n_mode == 2));
    for (int d = 0; d < int'($urandom_range(0, 2)); d++) begin
      @(negedge clk);
      chk(gnt_valid && gnt_id == ID_W'(id), "R12", gnt_valid, 1);
    end
    gnt_ready = 1'b1;
    @(negedge clk);
    gnt_ready = 1'b0;
    chk(req_ready == 1'b1, "R11", req_ready, 1);
    m_mode = n_mode; m_id = n_id;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int pool[5] = '{0, 1, 2, 3, 63};
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", req_ready, 1);
    chk(!inv_valid && !gnt_valid && !inv_rsp_ready, "R1", inv_valid, 0);
    txn(0, 1'b0, "R2");   // first read of uncached block
    txn(0, 1'b0, "R3");   // sole sharer re-reads
    txn(0, 1'b1, "R10");  // sole sharer upgrades, no invalidate
    txn(4, 1'b0, "R9");   // reader invalidates exclusive owner 0
    txn(4, 1'b0, "R3");
    txn(1, 1'b0, "R4");   // second sharer -> global
    txn(9, 1'b0, "R4");   // global read, no invalidate
    txn(2, 1'b1, "R5");   // broadcast, 63 responses
    txn(5, 1'b0, "R8");   // writer 2 recorded as exclusive holder
    txn(5, 1'b1, "R10");  // write by sole holder
    txn(7, 1'b1, "R6");   // directed invalidate to 5
    txn(7, 1'b0, "R10");  // owner reads its own block
    for (int i = 0; i < 40; i++)
      txn(pool[$urandom_range(0, 4)], 1'($urandom_range(0, 1)), "R6");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule